// File: doc/BRIEF.md
# GPU Power-Domain Controller

This block gates a handful of independent power domains inside a graphics core: one geometry domain, one L2 cache domain and four pixel-processor domains. Software talks to it through a word-addressed register port. A bitmask written to the switch-on register brings the named domains up. A bitmask written to the switch-off register brings them down. The controller handles the domains that actually change one at a time, lowest bit first. It holds each one for a settle time taken from a software-programmed delay register, and it reports progress in a state register in which a set bit means the domain is dark.

When a command finishes, the controller latches a completion flag in a raw event register, whatever the event enable register says. The enable register only decides whether the flag reaches the interrupt pin, and the flag stays until software acknowledges it. A switch-off command that leaves every domain dark finishes silently: it sets no flag. One further command may wait behind the running one. The real switches, isolation and clock gating sit outside the block, which drives only one enable line per domain.

Top module: `gpu_pwr_ctrl`

## Requirements
- R1: After reset the state register reads all ones, every `pwr_en` bit is 0, `irq` is 0, the event enable register reads 0, the raw event register reads 0 and the settle register reads 0xFFFF.
- R2: State register polarity: bit i is 1 when domain i is off and 0 when it is on. While no command is running, `pwr_en` equals the bitwise inverse of the state register.
- R3: A write to the switch-on register (word address 0) turns on exactly the domains whose data bits are set. A write to the switch-off register (word address 1) turns off exactly those domains. The state register (address 2) changes only while a command runs.
- R4: Mask bits that name domains already in the target state are ignored. A command that changes no domain completes after one settle period and still sets the completion flag.
- R5: The domains of one command are handled one at a time, from the lowest bit index upward, so at most one state bit changes on any clock edge.
- R6: Each domain step lasts D cycles, where D is the settle register (address 3, bits 15:0) sampled when the command starts. A value of 0 acts as 1. Domain k of a command, counted from 1, updates its state bit k·D cycles after the edge that starts the command.
- R7: When a command completes, bit 0 of the raw event register (address 4) is set, whatever the enable register holds, and it stays set until acknowledged.
- R8: Writing 1 to bit 0 of the acknowledge register (address 6) clears the raw completion bit. Writing 0 has no effect. A completion on the same edge wins over the acknowledge.
- R9: `irq` is 1 exactly when the raw completion bit and bit 0 of the enable register (address 5) are both 1. With the enable at 0, `irq` stays 0.
- R10: A switch-off command whose completion leaves every domain off does not set the completion bit.
- R11: A command written while another runs is held in a single slot and starts on the completion edge of the running one. A command written while the slot is full is discarded.
- R12: A read returns data on `rd_data` one cycle after `rd_en`, from the register values before that edge. Unmapped addresses read 0.
- R13: For a switch-on step the domain's `pwr_en` bit rises at the start of the step. For a switch-off step it falls at the start of the step. In both cases the state bit follows at the end of the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| pwr_en | output | 6 | Per-domain power enable (bit 0 geometry, bit 1 L2, bits 5:2 pixel) |
| irq | output | 1 | Completion interrupt, gated by enable |

## Verification
The assertions check, on every cycle, several invariants of the sequencer and the event logic. At most one state bit changes per edge. An idle controller keeps its state and drives enables that mirror it. A held command stays in its slot until the running command completes. The step counter stays inside the settle length. A disabled interrupt stays low, and the raw flag stays sticky. Other behaviour only the bench scenarios can show, by comparing against a behavioural model every clock. That covers the exact cycle of each step for a given settle value, the lowest-first order, the silent all-off switch-off, the discarding of a command that finds the slot full, and the settle value being sampled once per command.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PWR_ON  = 3'd0,
    A_PWR_OFF = 3'd1,
    A_STATE   = 3'd2,
    A_SETTLE  = 3'd3,
    A_IRQ_RAW = 3'd4,
    A_IRQ_EN  = 3'd5,
    A_IRQ_ACK = 3'd6
  } reg_addr_e;

  localparam int DONE_BIT = 0;

endpackage

// File: rtl/gpc_lsb_pick.sv
module gpc_lsb_pick #(
  parameter int W = 6
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] onehot
);

  logic [W:0] seen;

  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign onehot[i]  = vec[i] & ~seen[i];
      assign seen[i+1]  = seen[i] | vec[i];
    end
  endgenerate

endmodule

// File: rtl/gpc_sequencer.sv
module gpc_sequencer #(
  parameter int N_DOM = 6,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             cmd_up,
  input  logic [N_DOM-1:0] cmd_mask,
  input  logic [DLY_W-1:0] dly,
  output logic [N_DOM-1:0] status,
  output logic [N_DOM-1:0] pwr_en,
  output logic             set_raw
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  // registered state
  logic             busy_q, up_q;
  logic [N_DOM-1:0] todo_q, stat_q, pen_q;
  logic [DLY_W-1:0] cnt_q, len_q;
  logic             q_vld, q_up;
  logic [N_DOM-1:0] q_mask;

  // next-state logic
  logic             step_end, done, free, start, take_q, s_up;
  logic             busy_n, up_n, q_vld_n, q_up_n;
  logic [N_DOM-1:0] pick_cur, pick_nxt, todo_after, stat_mid;
  logic [N_DOM-1:0] s_mask, new_todo, todo_n, pen_n, q_mask_n;

  gpc_lsb_pick #(.W(N_DOM)) u_pick_cur (.vec(todo_q), .onehot(pick_cur));
  gpc_lsb_pick #(.W(N_DOM)) u_pick_nxt (.vec(todo_n), .onehot(pick_nxt));

  always_comb begin
    step_end   = busy_q && (cnt_q == len_q - ONE);
    todo_after = step_end ? (todo_q & ~pick_cur) : todo_q;

    stat_mid = stat_q;
    if (step_end) begin
      stat_mid = up_q ? (stat_q & ~pick_cur) : (stat_q | pick_cur);
    end

    done   = step_end && (todo_after == '0);
    free   = !busy_q || done;
    take_q = free && q_vld;
    start  = free && (q_vld || cmd_wr);

    s_up     = q_vld ? q_up   : cmd_up;
    s_mask   = q_vld ? q_mask : cmd_mask;
    new_todo = s_mask & (s_up ? stat_mid : ~stat_mid);

    busy_n = start ? 1'b1 : (done ? 1'b0 : busy_q);
    up_n   = start ? s_up : up_q;
    todo_n = start ? new_todo : todo_after;

    // one waiting slot
    q_vld_n  = q_vld;
    q_up_n   = q_up;
    q_mask_n = q_mask;
    if (take_q) begin
      q_vld_n = 1'b0;
    end
    if (cmd_wr && !(free && !q_vld) && !q_vld_n) begin
      q_vld_n  = 1'b1;
      q_up_n   = cmd_up;
      q_mask_n = cmd_mask;
    end

    // enable leads the state bit for the domain being stepped
    pen_n = ~stat_mid;
    if (busy_n) begin
      pen_n = up_n ? (pen_n | pick_nxt) : (pen_n & ~pick_nxt);
    end

    set_raw = done && !(!up_q && (&stat_mid));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      up_q   <= 1'b0;
      todo_q <= '0;
      stat_q <= '1;
      pen_q  <= '0;
      cnt_q  <= '0;
      len_q  <= ONE;
      q_vld  <= 1'b0;
      q_up   <= 1'b0;
      q_mask <= '0;
    end else begin
      busy_q <= busy_n;
      up_q   <= up_n;
      todo_q <= todo_n;
      stat_q <= stat_mid;
      pen_q  <= pen_n;
      q_vld  <= q_vld_n;
      q_up   <= q_up_n;
      q_mask <= q_mask_n;
      if (start || step_end) begin
        cnt_q <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + ONE;
      end
      if (start) begin
        len_q <= (dly == '0) ? ONE : dly;
      end
    end
  end

  assign status = stat_q;
  assign pwr_en = pen_q;

  // R5: one domain at a time
  p_one_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ($countones(stat_q ^ $past(stat_q)) <= 1));

  // R2: idle enables mirror the inverted state
  p_idle_pen_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (pen_q == ~stat_q));

  // R3: state only moves while a command runs
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(stat_q));

  // R11: a held command is kept until the slot frees
  p_queue_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (q_vld && !free) |=> q_vld);

  // R6: the step counter never passes the settle length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < len_q));

endmodule

// File: rtl/gpc_regif.sv
module gpc_regif
  import gpc_pkg::*;
#(
  parameter int               N_DOM   = 6,
  parameter int               DLY_W   = 16,
  parameter int               DATA_W  = 32,
  parameter logic [DLY_W-1:0] DLY_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_DOM-1:0]  status,
  input  logic              set_raw,
  output logic              cmd_wr,
  output logic              cmd_up,
  output logic [N_DOM-1:0]  cmd_mask,
  output logic [DLY_W-1:0]  dly,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  logic [DLY_W-1:0]  dly_q;
  logic              en_q, raw_q, irq_q;
  logic [DATA_W-1:0] rd_q, rd_n;
  logic              wr_on, wr_off, wr_settle, wr_en_reg, wr_ack;
  logic              raw_n, en_n;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:DLY_W];

  always_comb begin
    wr_on     = wr_en && (addr == A_PWR_ON);
    wr_off    = wr_en && (addr == A_PWR_OFF);
    wr_settle = wr_en && (addr == A_SETTLE);
    wr_en_reg = wr_en && (addr == A_IRQ_EN);
    wr_ack    = wr_en && (addr == A_IRQ_ACK);

    cmd_wr   = wr_on || wr_off;
    cmd_up   = wr_on;
    cmd_mask = wr_data[N_DOM-1:0];

    raw_n = raw_q;
    if (wr_ack && wr_data[DONE_BIT]) raw_n = 1'b0;
    if (set_raw) raw_n = 1'b1;
    en_n = wr_en_reg ? wr_data[DONE_BIT] : en_q;

    rd_n = '0;
    case (addr)
      A_STATE:   rd_n[N_DOM-1:0]  = status;
      A_SETTLE:  rd_n[DLY_W-1:0]  = dly_q;
      A_IRQ_RAW: rd_n[DONE_BIT]   = raw_q;
      A_IRQ_EN:  rd_n[DONE_BIT]   = en_q;
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= DLY_RST;
      en_q  <= 1'b0;
      raw_q <= 1'b0;
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (wr_settle) dly_q <= wr_data[DLY_W-1:0];
      en_q  <= en_n;
      raw_q <= raw_n;
      irq_q <= raw_n & en_n;
      if (rd_en) rd_q <= rd_n;
    end
  end

  assign dly     = dly_q;
  assign rd_data = rd_q;
  assign irq     = irq_q;

  // R9: interrupt held low while disabled
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq_q);

  // R7: raw completion flag is sticky
  p_raw_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !(wr_ack && wr_data[DONE_BIT])) |=> raw_q);

  // R8: acknowledge clears unless a completion coincides
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ack && wr_data[DONE_BIT] && !set_raw) |=> !raw_q);

endmodule

// File: rtl/gpu_pwr_ctrl.sv
module gpu_pwr_ctrl
  import gpc_pkg::*;
#(
  parameter int               N_DOM   = 6,
  parameter int               DLY_W   = 16,
  parameter int               DATA_W  = 32,
  parameter logic [DLY_W-1:0] DLY_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_DOM-1:0]  pwr_en,
  output logic              irq
);

  logic             cmd_wr, cmd_up, set_raw;
  logic [N_DOM-1:0] cmd_mask, status;
  logic [DLY_W-1:0] dly;

  gpc_regif #(
    .N_DOM(N_DOM), .DLY_W(DLY_W), .DATA_W(DATA_W), .DLY_RST(DLY_RST)
  ) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .status(status), .set_raw(set_raw),
    .cmd_wr(cmd_wr), .cmd_up(cmd_up), .cmd_mask(cmd_mask), .dly(dly),
    .rd_data(rd_data), .irq(irq)
  );

  gpc_sequencer #(
    .N_DOM(N_DOM), .DLY_W(DLY_W)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_up(cmd_up),
    .cmd_mask(cmd_mask), .dly(dly), .status(status), .pwr_en(pwr_en),
    .set_raw(set_raw)
  );

endmodule

// File: tb/test_gpu_pwr_ctrl.sv
`timescale 1ns/1ps
module test_gpu_pwr_ctrl;
  import gpc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [5:0]  pwr_en;
  logic        irq;

  int vectors = 0;
  int miscomp = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpu_pwr_ctrl i_gpu_pwr_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wdata), .rd_data(rd_data), .pwr_en(pwr_en), .irq(irq)
  );

  // behavioural reference model
  logic [5:0]  m_status, m_pen;
  logic [15:0] m_delay;
  bit          m_mask, m_raw, m_irq, m_busy, m_up, e_rd_v;
  int          m_cnt, m_d;
  int          m_list[$];
  int          q_up[$], q_m[$];
  logic [31:0] e_rd;

  task automatic m_start(input int up, input int msk, input logic [15:0] dl);
    m_busy = 1; m_up = up[0]; m_cnt = 0;
    m_d = (dl == 0) ? 1 : int'(dl);
    m_list.delete();
    for (int i = 0; i < 6; i++)
      if (msk[i] && (up[0] ? m_status[i] : !m_status[i])) m_list.push_back(i);
  endtask

  always @(posedge clk) begin
    logic [15:0] old_dly;
    bit is_cmd;
    if (rst) begin
      m_status = '1; m_pen = '0; m_delay = 16'hFFFF; m_mask = 0; m_raw = 0;
      m_irq = 0; m_busy = 0; e_rd_v = 0; m_list.delete(); q_up.delete(); q_m.delete();
    end else begin
      e_rd_v = rd_en;
      case (addr)
        3'd2: e_rd = {26'd0, m_status};
        3'd3: e_rd = {16'd0, m_delay};
        3'd4: e_rd = {31'd0, m_raw};
        3'd5: e_rd = {31'd0, m_mask};
        default: e_rd = '0;
      endcase
      old_dly = m_delay;
      if (wr_en) begin
        if (addr == 3'd3) m_delay = wdata[15:0];
        if (addr == 3'd5) m_mask = wdata[0];
        if (addr == 3'd6 && wdata[0]) m_raw = 0;
      end
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_d) begin
          m_cnt = 0;
          if (m_list.size() > 0) begin
            int idx;
            idx = m_list.pop_front();
            m_status[idx] = m_up ? 1'b0 : 1'b1;
          end
          if (m_list.size() == 0) begin
            m_busy = 0;
            if (m_up || !(&m_status)) m_raw = 1;
          end
        end
      end
      is_cmd = wr_en && (addr == 3'd0 || addr == 3'd1);
      if (!m_busy && q_m.size() > 0) m_start(q_up.pop_front(), q_m.pop_front(), old_dly);
      if (is_cmd) begin
        if (!m_busy) m_start((addr == 3'd0) ? 1 : 0, int'(wdata[5:0]), old_dly);
        else if (q_m.size() == 0) begin
          q_up.push_back((addr == 3'd0) ? 1 : 0); q_m.push_back(int'(wdata[5:0]));
        end
      end
      m_pen = ~m_status;
      if (m_busy && m_list.size() > 0) m_pen[m_list[0]] = m_up;
      m_irq = m_raw & m_mask;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscomp++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R13 pwr_en vs model", {26'd0, pwr_en}, {26'd0, m_pen});
      chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      if (e_rd_v) chk("R12 rd_data vs model", rd_data, e_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscomp++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 pwr_en reset", {26'd0, pwr_en}, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    rd(A_STATE, v);   chk("R1 state all off", v, 32'h3F);
    rd(A_SETTLE, v);  chk("R1 settle default", v, 32'hFFFF);
    rd(A_IRQ_EN, v);  chk("R1 enable cleared", v, 32'd0);
    rd(A_IRQ_RAW, v); chk("R1 raw cleared", v, 32'd0);

    // R5 R6 R13 timing of a two-domain switch-on, settle 3
    wr(A_SETTLE, 32'd3);
    wr(A_IRQ_EN, 32'd1);
    wr(A_PWR_ON, 32'h05);
    chk("R13 first enable rises at step start", {26'd0, pwr_en}, 32'h01);
    idle(2);
    chk("R6 second domain not started before D", {26'd0, pwr_en}, 32'h01);
    idle(1);
    chk("R5 next higher domain after first", {26'd0, pwr_en}, 32'h05);
    idle(6);
    rd(A_STATE, v);   chk("R3 R2 only bits 0 and 2 on", v, 32'h3A);
    rd(A_IRQ_RAW, v); chk("R7 completion latched", v, 32'd1);
    chk("R9 irq with enable set", {31'd0, irq}, 32'd1);

    // R8 acknowledge
    wr(A_IRQ_ACK, 32'd0);
    rd(A_IRQ_RAW, v); chk("R8 ack of 0 ignored", v, 32'd1);
    wr(A_IRQ_ACK, 32'd1);
    rd(A_IRQ_RAW, v); chk("R8 ack of 1 clears", v, 32'd0);

    // R4 nothing to change
    wr(A_PWR_ON, 32'h01);
    idle(4);
    rd(A_IRQ_RAW, v); chk("R4 no-change command completes", v, 32'd1);
    chk("R4 enables unchanged", {26'd0, pwr_en}, 32'h05);
    wr(A_IRQ_ACK, 32'd1);

    // R7 R9 with enable off
    wr(A_IRQ_EN, 32'd0);
    wr(A_PWR_ON, 32'h02);
    idle(6);
    rd(A_IRQ_RAW, v); chk("R7 raw set while disabled", v, 32'd1);
    chk("R9 irq held low while disabled", {31'd0, irq}, 32'd0);
    wr(A_IRQ_ACK, 32'd1);

    // R11 queue: run, held, discarded; settle change applies to the held one
    wr(A_PWR_ON, 32'h3F);
    wr(A_PWR_OFF, 32'h01);
    wr(A_PWR_OFF, 32'h02);
    wr(A_SETTLE, 32'd2);
    idle(25);
    rd(A_STATE, v); chk("R11 held ran, full-slot write dropped", v, 32'h01);
    chk("R11 enables follow", {26'd0, pwr_en}, 32'h3E);

    // R10 silent all-off, then a partial switch-off that does flag
    wr(A_IRQ_ACK, 32'd1);
    wr(A_PWR_OFF, 32'h3F);
    idle(20);
    rd(A_STATE, v);   chk("R10 all domains off", v, 32'h3F);
    rd(A_IRQ_RAW, v); chk("R10 no completion when all off", v, 32'd0);
    wr(A_PWR_ON, 32'h03);
    idle(8);
    wr(A_IRQ_ACK, 32'd1);
    wr(A_PWR_OFF, 32'h01);
    idle(6);
    rd(A_IRQ_RAW, v); chk("R10 partial switch-off flags", v, 32'd1);

    // R6 zero settle acts as one cycle
    wr(A_SETTLE, 32'd0);
    wr(A_PWR_ON, 32'h04);
    rd(A_STATE, v); chk("R6 zero settle one cycle", v, 32'h39);

    // R12 unmapped read
    rd(3'd7, v); chk("R12 unmapped reads zero", v, 32'd0);

    idle(3);
    finished = 1;
    summary();
    $finish;
  end

endmodule